// File: doc/BRIEF.md
# Dual-Bank Frame Shape Control

This block sits on the peripheral side of a two-wire audio bus and holds two copies of the frame control register, one per bank. One bank is live and drives the frame engine. The other bank is a staging area. The host reconfigures the frame by broadcasting a new frame control byte to the register of the idle bank. Because that write arms a swap, the frame shape never changes in the middle of a frame. The swap itself happens only on the next stream sync-point pulse.

When the swap takes place, the staged byte is decoded into a row count and a column count for the frame engine. The row decode is a non-linear lookup that has gaps in it. Any row index that falls in a reserved slot or outside the defined set raises an error flag and drops back to the smallest row count. The block also reports which bank is live and whether a swap is waiting.

Top module: `frame_bank_ctrl`

## Requirements
- R1: After reset, bank 0 is live (`live_bank`=0), the outputs read 48 rows and 2 columns, `swap_pending`=0 and `shape_bad`=0.
- R2: In the frame control byte, bits [2:0] are the column index and bits [7:3] are the row index. A column index k decodes to 2*(k+1) columns, so 0..7 gives 2..16.
- R3: Row index 0..14 decodes to 48, 50, 60, 64, 75, 80, 125, 147, 96, 100, 120, 128, 150, 160, 250. Row index 16..23 decodes to 192, 200, 240, 256, 72, 144, 90, 180.
- R4: Row index 15 and row indices 24..31 are invalid. Applying one of them gives 48 rows and sets `shape_bad`. The next swap that applies a valid byte clears `shape_bad`.
- R5: A write with `bus_bcast`=1 to the frame register address of the idle bank (bank 0 at `BANK0_ADDR`, bank 1 at `BANK1_ADDR`) stores the byte and sets `swap_pending` in the next cycle. At the next `sync_pulse`, the cycle after that pulse shows three changes: `live_bank` toggled, the rows and columns decoded from the staged byte, and `swap_pending` cleared.
- R6: A write to the live bank's frame register does not arm a swap and does not change any output.
- R7: A write to the idle bank's register with `bus_bcast`=0 does not arm a swap.
- R8: A second arming write before the sync point replaces the staged byte. The swap applies the last byte written.
- R9: A `sync_pulse` while no swap is pending changes nothing.
- R10: `live_bank`, `frame_rows`, `frame_cols` and `shape_bad` change only in the cycle after a sync pulse that applies a pending swap.
- R11: Writes to any address other than the two frame register addresses have no effect.
- R12: Suppose an arming write to the idle bank lands in the same cycle as a sync pulse that applies a pending swap. The swap then uses the byte held before that write, and the write leaves no swap pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register write address |
| reg_data | input | 8 | Register write data |
| bus_bcast | input | 1 | Write was addressed to all devices |
| sync_pulse | input | 1 | Stream sync-point pulse |
| live_bank | output | 1 | Bank currently in use |
| frame_rows | output | 9 | Decoded rows per frame |
| frame_cols | output | 5 | Decoded columns per frame |
| swap_pending | output | 1 | A bank swap is armed |
| shape_bad | output | 1 | Last applied byte had an invalid row index |

## Verification
The bench walks all 32 row indices through real swaps. A design with a shifted lookup would report the wrong rows. A design that leaves index 15 or 24..31 unchecked would emit 0 rows or miss the error flag. Non-broadcast writes, writes to the live bank and stray addresses are each followed by a sync pulse. A design that arms on any of them would toggle the bank. A write that collides with an applying sync shows whether the swap reads the old staged byte or the new one. It also shows whether that write wrongly leaves a swap armed. Random traffic mixed with these cases catches any output that moves outside an applied swap.

// File: rtl/frame_bank_pkg.sv
// Shared widths and the decoded frame shape record.
// Assumes: rows fit in 9 bits (max 256), columns in 5 bits (max 16).
package frame_bank_pkg;
    localparam int FB_ROW_W  = 9;
    localparam int FB_COL_W  = 5;
    localparam int FB_BYTE_W = 8;

    typedef struct packed {
        logic [FB_ROW_W-1:0] rows;
        logic [FB_COL_W-1:0] cols;
        logic                bad;
    } frame_shape_t;
endpackage

// File: rtl/frame_shape_decode.sv
// Decodes a frame control byte into rows and columns.
// Assumes: columns in bits [2:0], row index in bits [7:3]; an invalid
// row index maps to the smallest row count with the bad flag raised.
module frame_shape_decode
    import frame_bank_pkg::*;
(
    input  logic [FB_BYTE_W-1:0] code,
    output frame_shape_t         shape
);
    logic [4:0] row_idx;
    logic [2:0] col_idx;

    assign row_idx = code[7:3];
    assign col_idx = code[2:0];

    // Non-linear row lookup with reserved holes.
    always_comb begin
        shape.bad  = 1'b0;
        shape.cols = FB_COL_W'({col_idx, 1'b0}) + FB_COL_W'(2);
        case (row_idx)
            5'd0:    shape.rows = 9'd48;
            5'd1:    shape.rows = 9'd50;
            5'd2:    shape.rows = 9'd60;
            5'd3:    shape.rows = 9'd64;
            5'd4:    shape.rows = 9'd75;
            5'd5:    shape.rows = 9'd80;
            5'd6:    shape.rows = 9'd125;
            5'd7:    shape.rows = 9'd147;
            5'd8:    shape.rows = 9'd96;
            5'd9:    shape.rows = 9'd100;
            5'd10:   shape.rows = 9'd120;
            5'd11:   shape.rows = 9'd128;
            5'd12:   shape.rows = 9'd150;
            5'd13:   shape.rows = 9'd160;
            5'd14:   shape.rows = 9'd250;
            5'd16:   shape.rows = 9'd192;
            5'd17:   shape.rows = 9'd200;
            5'd18:   shape.rows = 9'd240;
            5'd19:   shape.rows = 9'd256;
            5'd20:   shape.rows = 9'd72;
            5'd21:   shape.rows = 9'd144;
            5'd22:   shape.rows = 9'd90;
            5'd23:   shape.rows = 9'd180;
            default: begin
                shape.rows = 9'd48;
                shape.bad  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/bank_regfile.sv
// Two frame control registers, one per bank, each at its own address.
// Assumes: any write strobe to a matching address updates that bank.
module bank_regfile
    import frame_bank_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] BANK0_ADDR = 8'h60,
    parameter logic [ADDR_W-1:0] BANK1_ADDR = 8'h70
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [FB_BYTE_W-1:0]          reg_data,
    output logic [1:0]                    hit,
    output logic [1:0][FB_BYTE_W-1:0]     bank_q
);
    localparam int NUM_BANKS = 2;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam logic [ADDR_W-1:0] MY_ADDR = (g == 0) ? BANK0_ADDR : BANK1_ADDR;

        assign hit[g] = reg_wr && (reg_addr == MY_ADDR);

        // Store the byte written to this bank; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)      bank_q[g] <= '0;
            else if (hit[g]) bank_q[g] <= reg_data;
        end
    end
endmodule

// File: rtl/bank_switch_ctrl.sv
// Tracks the live bank and the armed swap.
// Assumes: only a broadcast write to the idle bank arms; a swap applies
// on a sync pulse while armed, and a write in that cycle never re-arms.
module bank_switch_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] hit,
    input  logic       bus_bcast,
    input  logic       sync_pulse,
    output logic       live_bank,
    output logic       swap_pending,
    output logic       apply_swap
);
    logic arm;

    assign arm        = bus_bcast && hit[~live_bank];
    assign apply_swap = sync_pulse && swap_pending;

    // Toggle the live bank when a swap is applied.
    always_ff @(posedge clk) begin
        if (!rst_n)          live_bank <= 1'b0;
        else if (apply_swap) live_bank <= ~live_bank;
    end

    // Arm on a qualifying write, disarm when the swap applies.
    always_ff @(posedge clk) begin
        if (!rst_n)          swap_pending <= 1'b0;
        else if (apply_swap) swap_pending <= 1'b0;
        else if (arm)        swap_pending <= 1'b1;
    end

    assert_pending_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_pulse && swap_pending) |=> !swap_pending);

    assert_bank_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_pulse && swap_pending) |=> $stable(live_bank));

    assert_no_arm_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!swap_pending && !(bus_bcast && hit[~live_bank])) |=> !swap_pending);
endmodule

// File: rtl/frame_bank_ctrl.sv
// Top: dual-bank frame shape control. Registers the decoded shape of the
// staged bank when a pending swap is applied at a sync point.
// Assumes: reset is synchronous and active low; outputs are registered.
module frame_bank_ctrl
    import frame_bank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BANK0_ADDR = 8'h60,
    parameter logic [ADDR_W-1:0] BANK1_ADDR = 8'h70
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [7:0]           reg_data,
    input  logic                 bus_bcast,
    input  logic                 sync_pulse,
    output logic                 live_bank,
    output logic [8:0]           frame_rows,
    output logic [4:0]           frame_cols,
    output logic                 swap_pending,
    output logic                 shape_bad
);
    logic [1:0]                hit;
    logic [1:0][FB_BYTE_W-1:0] bank_q;
    logic                      apply_swap;
    frame_shape_t              staged_shape;

    bank_regfile #(
        .ADDR_W    (ADDR_W),
        .BANK0_ADDR(BANK0_ADDR),
        .BANK1_ADDR(BANK1_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .reg_wr  (reg_wr),
        .reg_addr(reg_addr),
        .reg_data(reg_data),
        .hit     (hit),
        .bank_q  (bank_q)
    );

    bank_switch_ctrl u_switch (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (hit),
        .bus_bcast   (bus_bcast),
        .sync_pulse  (sync_pulse),
        .live_bank   (live_bank),
        .swap_pending(swap_pending),
        .apply_swap  (apply_swap)
    );

    frame_shape_decode u_decode (
        .code (bank_q[~live_bank]),
        .shape(staged_shape)
    );

    // Latch the staged bank's shape when the swap takes effect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_rows <= 9'd48;
            frame_cols <= 5'd2;
            shape_bad  <= 1'b0;
        end else if (apply_swap) begin
            frame_rows <= staged_shape.rows;
            frame_cols <= staged_shape.cols;
            shape_bad  <= staged_shape.bad;
        end
    end

    assert_fallback_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shape_bad |-> (frame_rows == 9'd48));

    assert_cols_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_cols[0] == 1'b0) && (frame_cols >= 5'd2) && (frame_cols <= 5'd16));

    assert_shape_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_pulse && swap_pending) |=>
            ($stable(frame_rows) && $stable(frame_cols) && $stable(shape_bad)));

    assert_rows_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_rows != 9'd0);
endmodule

// File: tb/frame_bank_ctrl_bench.sv
`timescale 1ns/1ps
module frame_bank_ctrl_bench;
    localparam logic [7:0] A0 = 8'h60;
    localparam logic [7:0] A1 = 8'h70;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_data = '0;
    logic       bus_bcast = 1'b0;
    logic       sync_pulse = 1'b0;
    logic       live_bank, swap_pending, shape_bad;
    logic [8:0] frame_rows;
    logic [4:0] frame_cols;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] m_bank [2];
    logic       m_live, m_pend, m_bad;
    logic [8:0] m_rows;
    logic [4:0] m_cols;

    frame_bank_ctrl u_frame_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_data(reg_data), .bus_bcast(bus_bcast), .sync_pulse(sync_pulse),
        .live_bank(live_bank), .frame_rows(frame_rows), .frame_cols(frame_cols),
        .swap_pending(swap_pending), .shape_bad(shape_bad)
    );

    always #4 clk = ~clk;

    function automatic logic [8:0] exp_rows(input logic [4:0] i);
        case (i)
            0: return 48;   1: return 50;   2: return 60;   3: return 64;
            4: return 75;   5: return 80;   6: return 125;  7: return 147;
            8: return 96;   9: return 100;  10: return 120; 11: return 128;
            12: return 150; 13: return 160; 14: return 250;
            16: return 192; 17: return 200; 18: return 240; 19: return 256;
            20: return 72;  21: return 144; 22: return 90;  23: return 180;
            default: return 48;
        endcase
    endfunction

    function automatic logic row_invalid(input logic [4:0] i);
        return (i == 5'd15) || (i > 5'd23);
    endfunction

    task automatic check(input string tag);
        n_checks++;
        if (live_bank !== m_live || frame_rows !== m_rows || frame_cols !== m_cols ||
            swap_pending !== m_pend || shape_bad !== m_bad) begin
            n_fail++;
            $display("FAIL %s: got bank=%0d rows=%0d cols=%0d pend=%0d bad=%0d, exp bank=%0d rows=%0d cols=%0d pend=%0d bad=%0d",
                tag, live_bank, frame_rows, frame_cols, swap_pending, shape_bad,
                m_live, m_rows, m_cols, m_pend, m_bad);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, check at next negedge.
    task automatic cycle(input logic we, input logic [7:0] a, input logic [7:0] d,
                         input logic bc, input logic sy, input string tag);
        logic apply, arm;
        int   b;
        reg_wr = we; reg_addr = a; reg_data = d; bus_bcast = bc; sync_pulse = sy;
        @(posedge clk);
        apply = sy && m_pend;
        b = (a == A0) ? 0 : (a == A1) ? 1 : -1;
        arm = we && bc && (b >= 0) && (b != int'(m_live));
        if (apply) begin
            m_rows = exp_rows(m_bank[!m_live][7:3]);
            m_cols = 5'(2 * (int'(m_bank[!m_live][2:0]) + 1));
            m_bad  = row_invalid(m_bank[!m_live][7:3]);
            m_live = !m_live;
            m_pend = 1'b0;
        end else if (arm) begin
            m_pend = 1'b1;
        end
        if (we && b >= 0) m_bank[b] = d;
        @(negedge clk);
        check(tag);
    endtask

    function automatic logic [7:0] idle_addr();
        return m_live ? A0 : A1;
    endfunction

    function automatic logic [7:0] live_addr();
        return m_live ? A1 : A0;
    endfunction

    initial begin
        #(8.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout, exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_bank[0] = 0; m_bank[1] = 0;
        m_live = 0; m_pend = 0; m_bad = 0; m_rows = 48; m_cols = 2;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset state");

        // R3 R4 R2: every row index, with a varying column index, through a real swap.
        for (int i = 0; i < 32; i++) begin
            cycle(1, idle_addr(), {5'(i), 3'(i % 8)}, 1, 0, "R5 arm");
            cycle(0, 0, 0, 0, 1, row_invalid(5'(i)) ? "R4 invalid row" : "R3 row decode R2");
        end
        // R4: a valid swap clears the error.
        cycle(1, idle_addr(), 8'h1F, 1, 0, "R4 arm valid");
        cycle(0, 0, 0, 0, 1, "R4 error cleared");

        // R6: write to the live bank, then sync: nothing moves.
        cycle(1, live_addr(), 8'hA5, 1, 0, "R6 live write");
        cycle(0, 0, 0, 0, 1, "R6 no swap");
        // R7: non-broadcast to the idle bank does not arm.
        cycle(1, idle_addr(), 8'h42, 0, 0, "R7 unicast write");
        cycle(0, 0, 0, 0, 1, "R7 no swap");
        // R11: stray address.
        cycle(1, 8'h61, 8'h33, 1, 0, "R11 stray write");
        cycle(0, 0, 0, 0, 1, "R11 no swap");
        // R9: sync with nothing pending.
        cycle(0, 0, 0, 0, 1, "R9 idle sync");
        // R8: second write replaces staged byte.
        cycle(1, idle_addr(), 8'h00, 1, 0, "R8 first write");
        cycle(1, idle_addr(), {5'd19, 3'd7}, 1, 0, "R8 second write");
        cycle(0, 0, 0, 0, 0, "R10 hold while pending");
        cycle(0, 0, 0, 0, 1, "R8 last byte applied");
        // R12: arming write collides with applying sync.
        cycle(1, idle_addr(), {5'd2, 3'd1}, 1, 0, "R12 arm");
        cycle(1, idle_addr(), {5'd23, 3'd5}, 1, 1, "R12 old byte used, no re-arm");
        cycle(0, 0, 0, 0, 1, "R12 later sync idle");

        // Random traffic.
        for (int k = 0; k < 3000; k++) begin
            logic [2:0] sel;
            logic [7:0] ad;
            sel = 3'($urandom_range(0, 7));
            ad  = (sel < 3) ? A0 : (sel < 6) ? A1 : 8'($urandom);
            cycle($urandom_range(0, 1) == 1, ad, 8'($urandom),
                  $urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0, "R10 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule